// File: doc/BRIEF.md
# Module Presence Table Boot Reader

This block is a small power-on sequencer for a memory controller. When reset is released it reads, on its own, two bytes from the serial presence table that a memory module carries in a 256-byte two-wire EEPROM. It decodes them, holds the result and raises a completion flag. Normal memory traffic is meant to start only after that flag. The bus is driven in open-drain fashion: the block only ever pulls SCL or SDA low through output enables, and it reads the real SDA level back. External pull-ups supply the high level.

Each byte is fetched with a random-address read. The block writes the word address and then reads one byte back after a repeated START. The device address is the fixed EEPROM prefix followed by three strap pins. The first byte holds the module kind and the second holds the DRAM device density. Each raw byte is presented unchanged, together with one-hot kind flags, a density in megabits and flags for codes the block does not know. If the EEPROM fails to acknowledge any address phase, for example because the slot is empty, the block closes the bus with a STOP, reports an error and still completes.

The SCL rate comes from a quarter-period divider of the system clock. Arbitration, clock stretching and writes to the EEPROM are not part of the block.

Top module: `spd_boot_reader`

## Requirements
- R1: While reset is asserted, `done` is 0 and neither line is pulled (`scl_oe` = `sda_oe` = 0). After reset the first START is issued without any request, and `done` stays 0 while transfers are in progress.
- R2: Each byte is read with this sequence: START, address byte {1010, strap[2:0], 0}, word address, repeated START, address byte {1010, strap[2:0], 1}, 8 data bits answered by the master with NACK, STOP. All bytes go MSB first. Word address TYPE_ADDR (default 3) is read first and DENS_ADDR (default 4) second.
- R3: SDA changes only while SCL is low, except at START (SDA falls with SCL high) and STOP (SDA rises with SCL high). A full run therefore shows exactly four START conditions and two STOP conditions.
- R4: Every SCL low phase lasts exactly 2*QUARTER system clock cycles. Every SCL high phase lasts at least 2*QUARTER cycles.
- R5: Module kind from the first byte: 01h sets `is_rdimm` (registered), 02h sets `is_udimm` (unregistered), 03h sets `is_sodimm` (small outline). 00h (undefined) sets none of the flags. Any value above 03h sets `type_unknown`. At most one of these four outputs is 1.
- R6: Density from the second byte: 01h, 02h, 03h and 04h give `dens_mbit` = 512, 1024, 2048 and 4096. Any other value sets `dens_unsup` and gives `dens_mbit` = 0.
- R7: If the address byte of either direction or the word address is not acknowledged (SDA high in the ninth bit), the block issues one STOP, starts no further transfer, and sets `err` and `done`.
- R8: Once `done` is 1, `done`, `err`, `type_code` and `dens_code` hold their values until the next reset, and both lines stay released.
- R9: `type_code` and `dens_code` equal the bytes the EEPROM returned for the kind and density addresses. They read 00h for a byte that was never read.
- R10: All decode flags and `dens_mbit` are 0 unless `done` is 1 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap | input | 3 | Low three bits of the EEPROM device address |
| sda_i | input | 1 | Level of the SDA line as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | Boot read finished, with or without error |
| err | output | 1 | An address phase was not acknowledged |
| type_code | output | 8 | Raw module kind byte |
| dens_code | output | 8 | Raw device density byte |
| is_rdimm | output | 1 | Registered module |
| is_udimm | output | 1 | Unregistered module |
| is_sodimm | output | 1 | Small-outline module |
| type_unknown | output | 1 | Kind code above 03h |
| dens_unsup | output | 1 | Density code outside 01h to 04h |
| dens_mbit | output | 13 | Device density in megabits |

## Verification
The bench builds the block with QUARTER = 4, so an SCL period is 16 system clocks and a full two-byte boot read takes about 1300 cycles. That leaves room for more than twenty complete reset-to-done runs. The byte addresses keep their defaults of 3 and 4. The EEPROM model holds a different random table on every run. It can refuse any one of the three address phases or answer to a different strap value, which exercises each abort point. The short quarter period also makes it cheap to count the exact low and high phase lengths of every SCL pulse.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Operations the bit engine can run on the bus
  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_STOP  = 2'd1,
    BUS_XFER  = 2'd2
  } bus_op_e;

  // Boot sequencer states
  typedef enum logic [3:0] {
    SQ_BOOT,
    SQ_START,
    SQ_DEVW,
    SQ_WORD,
    SQ_RSTART,
    SQ_DEVR,
    SQ_READ,
    SQ_STOP,
    SQ_ABORT,
    SQ_END
  } seq_st_e;

  localparam logic [3:0] EEPROM_PREFIX = 4'b1010;
  localparam int unsigned FRAME_BITS  = 9;   // 8 data bits plus ack slot
  localparam int unsigned MBIT_W      = 13;
  localparam int unsigned MBIT_BASE   = 512;

endpackage

// File: rtl/spd_quarter_div.sv
module spd_quarter_div #(
  parameter int unsigned QUARTER = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spd_i2c_engine.sv
module spd_i2c_engine
  import spd_pkg::*;
#(
  parameter int unsigned QUARTER = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_read,
  input  logic       sda_i,
  output logic       eng_done,
  output logic [7:0] rx_byte,
  output logic       ack_ok,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  bus_op_e               op_q, op_d;
  logic [1:0]            ph_q, ph_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic                  scl_q, scl_d;
  logic                  sda_q, sda_d;
  logic                  done_q, done_d;
  logic                  tick;

  spd_quarter_div #(.QUARTER(QUARTER)) i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy_q),
    .tick  (tick)
  );

  // Each bus bit is four quarters: SCL low, SDA update, SCL high, sample/edge
  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (cmd_valid) begin
        busy_d = 1'b1;
        op_d   = cmd_op;
        ph_d   = 2'd0;
        bit_d  = '0;
        tx_d   = cmd_read ? '1 : {cmd_byte, 1'b1};
      end
    end else if (tick) begin
      unique case (ph_q)
        2'd0: scl_d = 1'b0;
        2'd1: begin
          unique case (op_q)
            BUS_START: sda_d = 1'b1;
            BUS_STOP:  sda_d = 1'b0;
            default:   sda_d = tx_q[FRAME_BITS-1];
          endcase
        end
        2'd2: scl_d = 1'b1;
        default: begin
          unique case (op_q)
            BUS_START: sda_d = 1'b0;
            BUS_STOP:  sda_d = 1'b1;
            default: begin
              rx_d = {rx_q[FRAME_BITS-2:0], sda_i};
              tx_d = {tx_q[FRAME_BITS-2:0], 1'b1};
            end
          endcase
        end
      endcase
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd3) begin
        if (op_q != BUS_XFER || bit_q == BIT_LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= BUS_START;
      ph_q   <= 2'd0;
      bit_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
    end
  end

  assign eng_done = done_q;
  assign rx_byte  = rx_q[FRAME_BITS-1:1];
  assign ack_ok   = !rx_q[0];
  assign scl_oe   = !scl_q;
  assign sda_oe   = !sda_q;
endmodule

// File: rtl/spd_fetch_seq.sv
module spd_fetch_seq
  import spd_pkg::*;
#(
  parameter logic [7:0] TYPE_ADDR = 8'd3,
  parameter logic [7:0] DENS_ADDR = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap,
  input  logic       eng_done,
  input  logic [7:0] rx_byte,
  input  logic       ack_ok,
  output logic       cmd_valid,
  output bus_op_e    cmd_op,
  output logic [7:0] cmd_byte,
  output logic       cmd_read,
  output logic       done,
  output logic       err,
  output logic [7:0] type_code,
  output logic [7:0] dens_code
);
  seq_st_e    st_q, st_d;
  logic       wait_q, wait_d;
  logic       idx_q, idx_d;
  logic       err_q, err_d;
  logic [7:0] type_q, type_d;
  logic [7:0] dens_q, dens_d;
  logic       issuing;

  assign issuing = (st_q != SQ_BOOT) && (st_q != SQ_END);

  always_comb begin
    st_d     = st_q;
    wait_d   = wait_q;
    idx_d    = idx_q;
    err_d    = err_q;
    type_d   = type_q;
    dens_d   = dens_q;
    cmd_op   = BUS_XFER;
    cmd_byte = '0;
    cmd_read = 1'b0;
    unique case (st_q)
      SQ_START, SQ_RSTART: cmd_op   = BUS_START;
      SQ_STOP, SQ_ABORT:   cmd_op   = BUS_STOP;
      SQ_DEVW:             cmd_byte = {EEPROM_PREFIX, strap, 1'b0};
      SQ_WORD:             cmd_byte = idx_q ? DENS_ADDR : TYPE_ADDR;
      SQ_DEVR:             cmd_byte = {EEPROM_PREFIX, strap, 1'b1};
      SQ_READ:             cmd_read = 1'b1;
      default: ;
    endcase
    cmd_valid = issuing && !wait_q;

    if (st_q == SQ_BOOT) begin
      st_d = SQ_START;
    end else if (issuing) begin
      if (!wait_q) begin
        wait_d = 1'b1;
      end else if (eng_done) begin
        wait_d = 1'b0;
        unique case (st_q)
          SQ_START:  st_d = SQ_DEVW;
          SQ_DEVW:   st_d = ack_ok ? SQ_WORD : SQ_ABORT;
          SQ_WORD:   st_d = ack_ok ? SQ_RSTART : SQ_ABORT;
          SQ_RSTART: st_d = SQ_DEVR;
          SQ_DEVR:   st_d = ack_ok ? SQ_READ : SQ_ABORT;
          SQ_READ: begin
            if (idx_q) dens_d = rx_byte;
            else       type_d = rx_byte;
            st_d = SQ_STOP;
          end
          SQ_STOP: begin
            if (idx_q) begin
              st_d = SQ_END;
            end else begin
              idx_d = 1'b1;
              st_d  = SQ_START;
            end
          end
          SQ_ABORT: begin
            err_d = 1'b1;
            st_d  = SQ_END;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_BOOT;
      wait_q <= 1'b0;
      idx_q  <= 1'b0;
      err_q  <= 1'b0;
      type_q <= '0;
      dens_q <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      type_q <= type_d;
      dens_q <= dens_d;
    end
  end

  assign done      = (st_q == SQ_END);
  assign err       = err_q;
  assign type_code = type_q;
  assign dens_code = dens_q;
endmodule

// File: rtl/spd_field_decode.sv
module spd_field_decode
  import spd_pkg::*;
(
  input  logic              valid,
  input  logic [7:0]        type_code,
  input  logic [7:0]        dens_code,
  output logic              is_rdimm,
  output logic              is_udimm,
  output logic              is_sodimm,
  output logic              type_unknown,
  output logic              dens_unsup,
  output logic [MBIT_W-1:0] dens_mbit
);
  localparam logic [MBIT_W-1:0] BASE = MBIT_W'(MBIT_BASE);

  always_comb begin
    is_rdimm     = 1'b0;
    is_udimm     = 1'b0;
    is_sodimm    = 1'b0;
    type_unknown = 1'b0;
    dens_unsup   = 1'b0;
    dens_mbit    = '0;
    if (valid) begin
      unique case (type_code)
        8'h00: ;
        8'h01: is_rdimm  = 1'b1;
        8'h02: is_udimm  = 1'b1;
        8'h03: is_sodimm = 1'b1;
        default: type_unknown = 1'b1;
      endcase
      if (dens_code >= 8'h01 && dens_code <= 8'h04) begin
        // code 1..4 -> shift 0..3 through a 2-bit wrap of (code - 1)
        dens_mbit = BASE << (dens_code[1:0] - 2'd1);
      end else begin
        dens_unsup = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_boot_reader.sv
module spd_boot_reader
  import spd_pkg::*;
#(
  parameter int unsigned QUARTER   = 125,
  parameter logic [7:0]  TYPE_ADDR = 8'd3,
  parameter logic [7:0]  DENS_ADDR = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        done,
  output logic        err,
  output logic [7:0]  type_code,
  output logic [7:0]  dens_code,
  output logic        is_rdimm,
  output logic        is_udimm,
  output logic        is_sodimm,
  output logic        type_unknown,
  output logic        dens_unsup,
  output logic [12:0] dens_mbit
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cmd_valid, cmd_read, eng_done, ack_ok;
  bus_op_e    cmd_op;
  logic [7:0] cmd_byte, rx_byte;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spd_i2c_engine #(.QUARTER(QUARTER)) i_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_read  (cmd_read),
    .sda_i     (sda_i),
    .eng_done  (eng_done),
    .rx_byte   (rx_byte),
    .ack_ok    (ack_ok),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  spd_fetch_seq #(.TYPE_ADDR(TYPE_ADDR), .DENS_ADDR(DENS_ADDR)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .strap     (strap),
    .eng_done  (eng_done),
    .rx_byte   (rx_byte),
    .ack_ok    (ack_ok),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_read  (cmd_read),
    .done      (done),
    .err       (err),
    .type_code (type_code),
    .dens_code (dens_code)
  );

  spd_field_decode i_dec (
    .valid        (done && !err),
    .type_code    (type_code),
    .dens_code    (dens_code),
    .is_rdimm     (is_rdimm),
    .is_udimm     (is_udimm),
    .is_sodimm    (is_sodimm),
    .type_unknown (type_unknown),
    .dens_unsup   (dens_unsup),
    .dens_mbit    (dens_mbit)
  );
endmodule

// File: rtl/spd_boot_reader_chk.sv
module spd_boot_reader_chk #(
  parameter int unsigned QUARTER = 125
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        done,
  input logic        err,
  input logic [7:0]  type_code,
  input logic [7:0]  dens_code,
  input logic        is_rdimm,
  input logic        is_udimm,
  input logic        is_sodimm,
  input logic        type_unknown,
  input logic        dens_unsup,
  input logic [12:0] dens_mbit
);
  localparam logic [15:0] LOW_SPAN = 16'(2 * QUARTER);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (scl_oe) low_cnt <= low_cnt + 16'd1;
    else             low_cnt <= '0;
  end

  a_r4_scl_low_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> low_cnt == LOW_SPAN);

  a_r5_kind_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_rdimm, is_udimm, is_sodimm, type_unknown}));

  a_r6_unsup_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dens_unsup |-> dens_mbit == 13'd0);

  a_r6_mbit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (dens_mbit != 13'd0) |-> $countones(dens_mbit) == 1);

  a_r7_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(err) && $stable(type_code) && $stable(dens_code));

  a_r8_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_oe && !sda_oe);

  a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || err) |-> !(is_rdimm || is_udimm || is_sodimm || type_unknown || dens_unsup)
                       && dens_mbit == 13'd0);
endmodule

bind spd_boot_reader spd_boot_reader_chk #(.QUARTER(QUARTER)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_oe       (scl_oe),
  .sda_oe       (sda_oe),
  .done         (done),
  .err          (err),
  .type_code    (type_code),
  .dens_code    (dens_code),
  .is_rdimm     (is_rdimm),
  .is_udimm     (is_udimm),
  .is_sodimm    (is_sodimm),
  .type_unknown (type_unknown),
  .dens_unsup   (dens_unsup),
  .dens_mbit    (dens_mbit)
);

// File: tb/test_spd_boot_reader.sv
`timescale 1ns/1ps
module test_spd_boot_reader;
  localparam int Q = 4;

  logic        clk;
  logic        rst_n;
  logic [2:0]  strap;
  logic        scl_oe, sda_oe, done, err;
  logic [7:0]  type_code, dens_code;
  logic        is_rdimm, is_udimm, is_sodimm, type_unknown, dens_unsup;
  logic [12:0] dens_mbit;
  logic        slv_low;
  logic        scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_low);

  spd_boot_reader #(.QUARTER(Q)) i_spd_boot_reader (
    .clk(clk), .rst_n(rst_n), .strap(strap), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .err(err),
    .type_code(type_code), .dens_code(dens_code),
    .is_rdimm(is_rdimm), .is_udimm(is_udimm), .is_sodimm(is_sodimm),
    .type_unknown(type_unknown), .dens_unsup(dens_unsup), .dens_mbit(dens_mbit)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  int n_run = 0;
  int n_fail = 0;

  // Behavioural EEPROM slave state
  logic [7:0] mem [0:255];
  logic [2:0] slv_strap;
  int         nack_sel;
  int         mode, cnt, starts, stops, devn, wn, ph_bad, hcnt, lcnt;
  logic [7:0] sh, ptr, txb;
  logic [7:0] devlog [0:7];
  logic [7:0] wlog [0:3];
  logic       rw, p_scl, p_sda;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_flags(input logic [7:0] t, input logic [7:0] d);
    exp_flags = {t == 8'h01, t == 8'h02, t == 8'h03, t > 8'h03, !(d >= 8'h01 && d <= 8'h04)};
  endfunction

  function automatic logic [12:0] exp_mbit(input logic [7:0] d);
    if (d >= 8'h01 && d <= 8'h04) exp_mbit = 13'(512 << (d - 8'h01));
    else                          exp_mbit = 13'd0;
  endfunction

  // Slave and bus monitor, evaluated away from the active edge
  initial begin
    slv_low = 1'b0; p_scl = 1'b1; p_sda = 1'b1;
    mode = 0; cnt = 0; starts = 0; stops = 0; devn = 0; wn = 0;
    ph_bad = 0; hcnt = 0; lcnt = 0; ptr = 8'h00; sh = 8'h00; txb = 8'h00; rw = 1'b0;
    forever begin
      logic sc, sd, acked;
      @(negedge clk);
      sc = scl_line;
      sd = sda_line;
      if (sc && !p_scl) begin
        if (lcnt != 2 * Q) ph_bad++;
        lcnt = 0;
      end
      if (!sc && p_scl) begin
        if (hcnt < 2 * Q) ph_bad++;
        hcnt = 0;
      end
      if (sc) hcnt++; else lcnt++;
      if (sc && p_scl && p_sda && !sd) begin
        mode = 1; cnt = 0; slv_low = 1'b0; starts++;
      end else if (sc && p_scl && !p_sda && sd) begin
        mode = 0; slv_low = 1'b0; stops++;
      end else if (sc && !p_scl) begin
        if (mode == 1 || mode == 2) begin
          if (cnt < 8) sh = {sh[6:0], sd};
          cnt++;
        end else if (mode == 3) begin
          cnt++;
        end
      end else if (!sc && p_scl) begin
        if (cnt == 8) begin
          if (mode == 1) begin
            if (devn < 8) devlog[devn] = sh;
            devn++;
            rw = sh[0];
            acked = (sh[7:1] == {4'b1010, slv_strap}) && !(nack_sel == 1 && !rw) && !(nack_sel == 3 && rw);
            if (acked) slv_low = 1'b1; else mode = 4;
          end else if (mode == 2) begin
            if (wn < 4) wlog[wn] = sh;
            wn++;
            if (nack_sel != 2) begin ptr = sh; slv_low = 1'b1; end
            else mode = 4;
          end else if (mode == 3) begin
            slv_low = 1'b0;
          end
        end else if (cnt == 9) begin
          cnt = 0;
          slv_low = 1'b0;
          if (mode == 1) begin
            if (rw) begin
              mode = 3; txb = mem[ptr]; ptr = ptr + 8'd1; slv_low = !txb[7];
            end else mode = 2;
          end else if (mode == 2 || mode == 3) begin
            mode = 4;
          end
        end else if (mode == 3 && cnt >= 1 && cnt <= 7) begin
          slv_low = !txb[7 - cnt];
        end
      end
      p_scl = sc;
      p_sda = sd;
    end
  end

  task automatic run_case(input logic [2:0] dstrap, input logic [2:0] sstrap,
                          input logic [7:0] tb, input logic [7:0] db, input int nk);
    logic [7:0] aw, ar, et, ed;
    logic [4:0] ef;
    logic [12:0] em;
    int waited, eff;
    logic [7:0] t_hold;
    @(posedge clk);
    rst_n = 1'b0;
    strap = dstrap;
    slv_strap = sstrap;
    nack_sel = nk;
    starts = 0; stops = 0; devn = 0; wn = 0; ph_bad = 0; lcnt = 0; hcnt = 0; mode = 0; cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    mem[3] = tb;
    mem[4] = db;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    chk("R1", "bus pulled in reset", {30'd0, scl_oe, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    // R1: first START taken without request, not yet done
    chk("R1", "auto start count", 32'(starts), 32'd1);
    chk("R1", "done early", {31'd0, done}, 32'd0);
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk("R7", "run completes", {31'd0, done}, 32'd1);
    eff = (sstrap != dstrap) ? 1 : nk;
    aw = {4'b1010, dstrap, 1'b0};
    ar = {4'b1010, dstrap, 1'b1};
    // R4: SCL phase lengths over the whole run
    chk("R4", "scl phase violations", 32'(ph_bad), 32'd0);
    if (eff == 0) begin
      et = tb; ed = db; ef = exp_flags(tb, db); em = exp_mbit(db);
      chk("R7", "err clear", {31'd0, err}, 32'd0);
      chk("R3", "start count", 32'(starts), 32'd4);
      chk("R3", "stop count", 32'(stops), 32'd2);
      chk("R2", "addr bytes seen", 32'(devn), 32'd4);
      chk("R2", "dev write byte", {24'd0, devlog[0]}, {24'd0, aw});
      chk("R2", "dev read byte", {24'd0, devlog[1]}, {24'd0, ar});
      chk("R2", "second dev write", {24'd0, devlog[2]}, {24'd0, aw});
      chk("R2", "second dev read", {24'd0, devlog[3]}, {24'd0, ar});
      chk("R2", "first word addr", {24'd0, wlog[0]}, 32'd3);
      chk("R2", "second word addr", {24'd0, wlog[1]}, 32'd4);
    end else begin
      et = 8'h00; ed = 8'h00; ef = 5'd0; em = 13'd0;
      chk("R7", "err set", {31'd0, err}, 32'd1);
      chk("R7", "starts before abort", 32'(starts), (eff == 3) ? 32'd2 : 32'd1);
      chk("R7", "single stop", 32'(stops), 32'd1);
      chk("R7", "addr bytes seen", 32'(devn), (eff == 3) ? 32'd2 : 32'd1);
    end
    chk("R9", "type_code", {24'd0, type_code}, {24'd0, et});
    chk("R9", "dens_code", {24'd0, dens_code}, {24'd0, ed});
    chk("R5", "kind flags", {27'd0, is_rdimm, is_udimm, is_sodimm, type_unknown, dens_unsup}, {27'd0, ef});
    chk("R6", "density mbit", {19'd0, dens_mbit}, {19'd0, em});
    if (err) chk("R10", "flags gated on error", {18'd0, dens_mbit, is_rdimm}, 32'd0);
    t_hold = type_code;
    repeat (40) @(negedge clk);
    chk("R8", "done held", {31'd0, done}, 32'd1);
    chk("R8", "type held", {24'd0, type_code}, {24'd0, t_hold});
    chk("R8", "lines released", {30'd0, scl_line, sda_line}, 32'd3);
    chk("R7", "no start after end", 32'(starts), (eff == 0) ? 32'd4 : ((eff == 3) ? 32'd2 : 32'd1));
  endtask

  initial begin
    rst_n = 1'b0;
    strap = 3'd0;
    slv_strap = 3'd0;
    nack_sel = 0;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    // Directed decodes (R5, R6)
    run_case(3'd2, 3'd2, 8'h02, 8'h03, 0);
    run_case(3'd0, 3'd0, 8'h01, 8'h04, 0);
    run_case(3'd7, 3'd7, 8'h03, 8'h01, 0);
    run_case(3'd5, 3'd5, 8'h00, 8'h00, 0);
    run_case(3'd1, 3'd1, 8'h7F, 8'h05, 0);
    run_case(3'd4, 3'd4, 8'h04, 8'hFF, 0);
    // Randomised tables and straps
    for (int k = 0; k < 8; k++) begin
      logic [2:0] s;
      logic [7:0] t, d;
      s = 3'($urandom);
      t = (k % 3 == 0) ? 8'($urandom) : 8'($urandom_range(0, 5));
      d = (k % 3 == 1) ? 8'($urandom) : 8'($urandom_range(0, 6));
      run_case(s, s, t, d, 0);
    end
    // R7: each abort point, including an empty or mismatched slot
    run_case(3'd3, 3'd6, 8'h02, 8'h02, 0);
    run_case(3'd3, 3'd3, 8'h02, 8'h02, 1);
    run_case(3'd2, 3'd2, 8'h01, 8'h03, 2);
    run_case(3'd6, 3'd6, 8'h03, 8'h04, 3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule